// File: doc/BRIEF.md
# SCL Clock Generator with Multi-Master Synchronization

This block produces the serial clock for one master on a two-wire bus whose clock line is a wired-AND of every device. It pulls the line low for a programmed low time and then lets go. It does not start timing the high time until it sees, through a synchronizer, that the line has really gone high. If some other device drags the line low again before the high time is over, this master drops its high count and begins a new low phase of its own. Every master on the bus therefore follows one shared clock, and the slowest participant sets its pace.

A 3-bit rate code sets the exponent `n`. The low time is `2^n` system clocks and the high time is `2^n + 8` system clocks. The output is a pull-down enable, where asserted means drive the pad low. Two single-cycle strobes tell the data-shifting logic when a low phase and a counted high phase begin.

Top module: `scl_sync_gen`

## Requirements
- R1: Each low phase keeps `scl_pull` asserted for exactly `2^n` consecutive clock cycles.
- R2: `rate_sel` codes 0 through 6 select `n = 4 + rate_sel`, giving `n` from 4 to 10.
- R3: After the low phase the block deasserts `scl_pull`. While the synchronized bus line stays low it waits, does not count and raises no `high_start`.
- R4: A counted high phase lasts `2^n + 8` cycles from the `high_start` strobe to the next `low_start` strobe, unless another device cuts it short.
- R5: `scl_bus_in` passes through a two-flop synchronizer. `high_start` rises 3 cycles after the bus line goes high.
- R6: When the bus line goes low during a counted high phase, the block asserts `low_start` and `scl_pull` 3 cycles later and then runs a full low phase.
- R7: While `en` is low or reset is asserted, `scl_pull`, `low_start` and `high_start` are all low. Raising `en` starts a low phase on the next cycle.
- R8: `rate_sel` code 7 behaves like code 6 (`n = 10`).
- R9: `low_start` and `high_start` are single-cycle pulses and are never high together.
- R10: With no other device on the bus and the pad looped back, `low_start` pulses repeat every `2^(n+1) + 11` cycles. That is the low time plus the high time plus the 3-cycle synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle and releases the line |
| rate_sel | input | 3 | Rate code selecting the exponent n |
| scl_bus_in | input | 1 | Raw sampled level of the shared clock line |
| scl_pull | output | 1 | Pad pull-down enable (1 = drive low) |
| low_start | output | 1 | One-cycle pulse at the start of each low phase |
| high_start | output | 1 | One-cycle pulse at the start of each counted high phase |

## Verification
The bench loops the pad back through a wired-AND model and sweeps all eight rate codes. For each code it measures the low length, the release-to-high-start delay, the high length and the full period. A design that mapped the codes wrongly, or that clipped code 7 to anything other than n = 10, gives lengths that are off by a power of two. A second master is modelled that stretches the low phase. If the design counted the high time from its own release instead of from the observed line, `high_start` would come early. The same second master also pulls the line low partway through a high phase. If the design ignored that, the next low phase would be late by the rest of the high count. Finally `en` is dropped in mid-phase, and a design that finished its current phase would leave the line pulled low.

// File: rtl/scl_sync_pkg.sv
`timescale 1ns/1ps
package scl_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Exponent for a rate code, clipped at the largest supported value.
  function automatic int unsigned rate_exp(input int unsigned code,
                                           input int unsigned n_min,
                                           input int unsigned n_max);
    int unsigned e;
    e = n_min + code;
    if (e > n_max) e = n_max;
    return e;
  endfunction

endpackage

// File: rtl/scl_bit_sync.sv
`timescale 1ns/1ps
module scl_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= {STAGES{RST_VAL}};
    else        shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];

endmodule

// File: rtl/scl_phase_cnt.sv
`timescale 1ns/1ps
module scl_phase_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | run;
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == limit - W'(1));

  // R1 / R4: a running count never passes the length of its phase
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/scl_sync_gen.sv
`timescale 1ns/1ps
module scl_sync_gen
  import scl_sync_pkg::*;
#(
  parameter int unsigned N_MIN       = 4,
  parameter int unsigned N_MAX       = 10,
  parameter int unsigned HIGH_EXTRA  = 8,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             scl_bus_in,
  output logic             scl_pull,
  output logic             low_start,
  output logic             high_start
);

  localparam int unsigned CNT_W = N_MAX + 2;

  logic             rst_core_n;
  logic             bus_hi;
  scl_phase_e       phase_q, phase_d;
  logic             low_stb_q, high_stb_q;
  logic             enter_low, enter_high;
  logic             cnt_clr, cnt_run, cnt_done;
  logic [CNT_W-1:0] low_len, high_len, cnt_limit;
  int unsigned      exp_n;

  // Reset: asserted asynchronously, released on a clock edge
  scl_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  // Bus line synchronizer
  scl_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_bus_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (scl_bus_in),
    .q     (bus_hi)
  );

  // Phase lengths from the rate code
  always_comb begin
    exp_n    = rate_exp(32'(rate_sel), N_MIN, N_MAX);
    low_len  = {{(CNT_W-1){1'b0}}, 1'b1} << exp_n;
    high_len = low_len + CNT_W'(HIGH_EXTRA);
  end

  // Next phase
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: phase_d = PH_LOW;
      PH_LOW:  if (cnt_done) phase_d = PH_WAIT;
      PH_WAIT: if (bus_hi) phase_d = PH_HIGH;
      PH_HIGH: if (!bus_hi || cnt_done) phase_d = PH_LOW;
      default: phase_d = PH_IDLE;
    endcase
    if (!en) phase_d = PH_IDLE;
  end

  always_comb begin
    enter_low  = (phase_d == PH_LOW)  && (phase_q != PH_LOW);
    enter_high = (phase_d == PH_HIGH) && (phase_q != PH_HIGH);
    cnt_run    = (phase_q == PH_LOW) || (phase_q == PH_HIGH);
    cnt_clr    = (phase_d != phase_q);
    cnt_limit  = (phase_q == PH_HIGH) ? high_len : low_len;
  end

  scl_phase_cnt #(.W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (cnt_clr),
    .run   (cnt_run),
    .limit (cnt_limit),
    .done  (cnt_done)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q    <= PH_IDLE;
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      low_stb_q  <= enter_low;
      high_stb_q <= enter_high;
    end
  end

  assign scl_pull   = (phase_q == PH_LOW);
  assign low_start  = low_stb_q;
  assign high_start = high_stb_q;

  // R9: strobes are exclusive single pulses
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(low_start && high_start));
  p_low_pulse_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    low_start |=> !low_start);
  p_high_pulse_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    high_start |=> !high_start);

  // R6: a low phase starts with the line pulled
  p_low_start_pulls_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    low_start |-> scl_pull);

  // R6: a low bus line during the counted high phase restarts the low phase
  p_high_abort_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase_q == PH_HIGH && !bus_hi && en) |=> (scl_pull && low_start));

  // R3: no high count while the line is held low
  p_wait_no_count_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase_q == PH_WAIT && !bus_hi) |=> !high_start);

  // R7: disabling releases the line and silences the strobes
  p_disable_release_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !en |=> (!scl_pull && !low_start && !high_start));

endmodule

// File: tb/test_scl_sync_gen.sv
`timescale 1ns/1ps
module test_scl_sync_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] rate_sel;
  logic       other_pull;
  logic       scl_bus;
  logic       scl_pull, low_start, high_start;

  int  cyc      = 0;
  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign scl_bus = !(scl_pull || other_pull);

  scl_sync_gen i_scl_sync_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .rate_sel   (rate_sel),
    .scl_bus_in (scl_bus),
    .scl_pull   (scl_pull),
    .low_start  (low_start),
    .high_start (high_start)
  );

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // which: 0 low_start, 1 high_start, 2 line released
  task automatic wait_ev(input int which, output int t);
    bit hit;
    t = -1;
    for (int i = 0; i < 6000; i++) begin
      step();
      case (which)
        0: hit = low_start;
        1: hit = high_start;
        default: hit = !scl_pull;
      endcase
      if (hit) begin
        t = cyc;
        break;
      end
    end
    if (t < 0) check(1'b0, "timeout", which, 1);
  endtask

  function automatic int exp_of(input int code);
    return (code > 6) ? 10 : code + 4;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int t0, tf, th, t2, te, lo, hi;
    bit bad;
    rst_n = 1'b0; en = 1'b0; rate_sel = 3'd0; other_pull = 1'b0;
    repeat (3) step();
    // R7: reset state
    check(!scl_pull, "R7 reset pull", int'(scl_pull), 0);
    check(!low_start && !high_start, "R7 reset strobes", int'(low_start | high_start), 0);
    rst_n = 1'b1;
    repeat (5) step();
    check(!scl_pull, "R7 idle while disabled", int'(scl_pull), 0);

    // Sweep every rate code, standalone on the bus
    for (int code = 0; code < 8; code++) begin
      lo = 1 << exp_of(code);
      hi = lo + 8;
      en = 1'b0;
      repeat (3) step();
      rate_sel = 3'(code);
      en = 1'b1;
      te = cyc;
      wait_ev(0, t0);
      check(t0 == te + 1, "R7 start after enable", t0 - te, 1);
      wait_ev(2, tf);
      check(tf - t0 == lo, (code == 7) ? "R8 low length code 7" : "R1 R2 low length", tf - t0, lo);
      wait_ev(1, th);
      check(th - tf == 3, "R5 R3 release to high_start", th - tf, 3);
      step();
      check(!high_start, "R9 high_start one cycle", int'(high_start), 0);
      wait_ev(0, t2);
      check(t2 - th == hi, "R4 high length", t2 - th, hi);
      check(t2 - t0 == 2 * lo + 11, "R10 period", t2 - t0, 2 * lo + 11);
      step();
      check(!low_start, "R9 low_start one cycle", int'(low_start), 0);
    end

    // Another master stretches the low phase (code 0: low 16, high 24)
    en = 1'b0;
    repeat (3) step();
    rate_sel = 3'd0;
    en = 1'b1;
    wait_ev(0, t0);
    other_pull = 1'b1;
    bad = 1'b0;
    while (cyc < t0 + 30) begin
      step();
      if (high_start) bad = 1'b1;
      if (cyc == t0 + 16)
        check(!scl_pull, "R3 release while stretched", int'(scl_pull), 0);
    end
    check(!bad, "R3 no high_start while line held low", int'(bad), 0);
    other_pull = 1'b0;
    wait_ev(1, th);
    check(th == t0 + 33, "R3 R5 high count from observed rise", th - t0, 33);

    // Another master cuts the high phase short
    while (cyc < th + 5) step();
    check(!scl_pull, "R6 released during high phase", int'(scl_pull), 0);
    other_pull = 1'b1;
    step();
    other_pull = 1'b0;
    wait_ev(0, t2);
    check(t2 == th + 8, "R6 low_start after interruption", t2 - th, 8);
    check(scl_pull, "R6 pull with low_start", int'(scl_pull), 1);
    wait_ev(2, tf);
    check(tf - t2 == 16, "R6 R1 full low after interruption", tf - t2, 16);

    // Disable in mid low phase
    wait_ev(0, t0);
    repeat (4) step();
    en = 1'b0;
    step();
    check(!scl_pull, "R7 release on disable", int'(scl_pull), 0);
    bad = 1'b0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (scl_pull || low_start || high_start) bad = 1'b1;
    end
    check(!bad, "R7 stays idle while disabled", int'(bad), 0);

    finish_run();
  end

endmodule